// File: doc/BRIEF.md
# Link Power-Up Reset Sequencer

This block brings a serial-link controller and its PHY out of reset in a fixed order, and takes them back down on request. It switches on the supply and then a group of clock enables, one per cycle. It releases PHY power-down and, after a short programmable gap, turns on the reference clock. It then lets the clocks settle and holds the endpoint reset pin at its active level for a long programmable interval. After that it releases the endpoint reset and then the PHY reset, and polls a PLL lock indication a bounded number of times. Once lock is seen it releases the core reset and then raises ready. If lock never comes, it raises a timeout flag and stays there.

Each clock enable has a failure status input that is checked in the cycle after that enable turns on. A failure unwinds the clocks that are already on, newest first, then drops the supply and returns to idle. A shutdown input returns every output to its reset value on the next clock edge, from any state. All delays are given in microseconds and converted to cycles from a reference-frequency parameter, rounded up. The PLL lock input is asynchronous and passes through a two-flop synchronizer.

Top module: `link_pwrup_seq`

## Requirements
- R1: While reset is applied, and while idle, the outputs are: supply off, all clock enables off, PHY power-down high, reference clock off, PHY and core resets high (asserted), endpoint reset at its active level, ready low, timeout low.
- R2: A start pulse in idle turns on the supply at the next edge. Clock enable bit 0 (PHY clock), bit 1 (bus clock) and bit 2 (core clock) then turn on at the following three edges, and PHY power-down is released one edge after the last clock.
- R3: The reference clock is enabled exactly PD_CYC cycles after PHY power-down is released, where any X_CYC = ceil(REF_KHZ * X_US / 1000).
- R4: The endpoint reset goes inactive exactly SETTLE_CYC + HOLD_CYC cycles after the reference clock is enabled.
- R5: The endpoint reset pin equals ep_active_hi_i while asserted and its inverse once released.
- R6: The PHY reset is released exactly one cycle after the endpoint reset goes inactive.
- R7: The synchronized lock is sampled every POLL_CYC cycles after PHY reset release. A lock input that goes high n cycles after that release is first seen at poll k = ceil((n+3)/POLL_CYC), and the core reset is released at cycle k*POLL_CYC.
- R8: If none of the LOCK_TRIES polls sees lock, lock_timeout_o rises exactly LOCK_TRIES*POLL_CYC cycles after PHY reset release, while ready stays low and the core reset stays asserted.
- R9: Ready rises exactly one cycle after the core reset is released and stays high until shutdown.
- R10: A clock failure seen in the cycle after enable k turns on stops the bring-up. The enabled clocks turn off one per cycle, highest index first, and the supply turns off only once all clocks are off. PHY power-down is never released.
- R11: A shutdown pulse returns every output to its R1 value at the next edge from any state, and takes priority over a simultaneous start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin power-up from idle |
| shutdown_i | input | 1 | Return to the reset state |
| ep_active_hi_i | input | 1 | Active level of the endpoint reset pin |
| clk_fail_i | input | NUM_CLK | Per-clock enable failure status |
| pll_lock_i | input | 1 | Asynchronous PHY PLL lock |
| supply_en_o | output | 1 | Supply enable |
| clk_en_o | output | NUM_CLK | Clock enables: 0 PHY, 1 bus, 2 core |
| phy_pd_o | output | 1 | PHY power-down, high = powered down |
| refclk_en_o | output | 1 | Reference clock path enable |
| ep_rst_o | output | 1 | Endpoint reset pin |
| phy_rst_o | output | 1 | PHY reset, high = asserted |
| core_rst_o | output | 1 | Core reset, high = asserted |
| ready_o | output | 1 | Bring-up complete |
| lock_timeout_o | output | 1 | PLL lock never seen |

## Verification
The bench builds the block with a 2 MHz reference and short intervals: 6 cycles of power-down gap, 10 of settle, 16 of endpoint hold, and a 4-cycle poll interval with 4 tries. With these values a whole bring-up takes about sixty cycles. That makes it possible to sweep both pin polarities against every lock arrival offset across the full poll window, including each offset that just misses a poll through the synchronizer. It also fails each clock position in turn, and issues a shutdown at every cycle of a bring-up.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SUPPLY,
    ST_CLK,
    ST_UNWIND,
    ST_PD_REL,
    ST_SETTLE,
    ST_EP_HOLD,
    ST_EP_REL,
    ST_POLL,
    ST_CORE_REL,
    ST_READY,
    ST_TIMEOUT
  } lps_state_e;

  typedef struct packed {
    logic supply;
    logic phy_pd;
    logic refclk;
    logic ep_asserted;
    logic phy_rst;
    logic core_rst;
    logic ready;
    logic timeout;
  } lps_out_t;

  localparam lps_out_t LPS_OUT_RST = '{supply: 1'b0, phy_pd: 1'b1, refclk: 1'b0,
                                       ep_asserted: 1'b1, phy_rst: 1'b1,
                                       core_rst: 1'b1, ready: 1'b0, timeout: 1'b0};

  // Microseconds to cycles, rounded up, never below one cycle.
  function automatic longint unsigned us2cyc(longint unsigned khz, longint unsigned us);
    longint unsigned c;
    c = (khz * us + 64'd999) / 64'd1000;
    if (c == 64'd0) c = 64'd1;
    return c;
  endfunction

  function automatic lps_out_t decode(lps_state_e st);
    lps_out_t o;
    o = LPS_OUT_RST;
    case (st)
      ST_IDLE:     o = LPS_OUT_RST;
      ST_SUPPLY,
      ST_CLK,
      ST_UNWIND:   o.supply = 1'b1;
      ST_PD_REL:   begin o.supply = 1'b1; o.phy_pd = 1'b0; end
      ST_SETTLE,
      ST_EP_HOLD:  begin o.supply = 1'b1; o.phy_pd = 1'b0; o.refclk = 1'b1; end
      ST_EP_REL:   begin
                     o.supply = 1'b1; o.phy_pd = 1'b0; o.refclk = 1'b1;
                     o.ep_asserted = 1'b0;
                   end
      ST_POLL,
      ST_TIMEOUT:  begin
                     o.supply = 1'b1; o.phy_pd = 1'b0; o.refclk = 1'b1;
                     o.ep_asserted = 1'b0; o.phy_rst = 1'b0;
                     o.timeout = (st == ST_TIMEOUT);
                   end
      ST_CORE_REL,
      ST_READY:    begin
                     o.supply = 1'b1; o.phy_pd = 1'b0; o.refclk = 1'b1;
                     o.ep_asserted = 1'b0; o.phy_rst = 1'b0; o.core_rst = 1'b0;
                     o.ready = (st == ST_READY);
                   end
      default:     o = LPS_OUT_RST;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/lps_sync2.sv
module lps_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lps_timer.sv
module lps_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign done_o = (cnt_q == '0);
  assign cnt_en = load_i | ~done_o;

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
#(
  parameter int unsigned NUM_CLK    = 3,
  parameter int unsigned TW         = 8,
  parameter int unsigned LOCK_TRIES = 4,
  parameter int unsigned PD_CYC     = 1,
  parameter int unsigned SETTLE_CYC = 1,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned POLL_CYC   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               shutdown_i,
  input  logic [NUM_CLK-1:0] clk_fail_i,
  input  logic               lock_i,
  input  logic               tmr_done_i,
  output logic               tmr_load_o,
  output logic [TW-1:0]      tmr_val_o,
  output logic [NUM_CLK-1:0] clk_en_o,
  output lps_out_t           out_o
);

  localparam int unsigned IW = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1;
  localparam int unsigned RW = $clog2(LOCK_TRIES + 1);

  lps_state_e         state_q, state_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [RW-1:0]      tries_q, tries_d;
  logic [NUM_CLK-1:0] clken_q, clken_d;
  lps_out_t           out_q;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    tries_d    = tries_q;
    clken_d    = clken_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (shutdown_i) begin
      state_d = ST_IDLE;
      idx_d   = '0;
      tries_d = '0;
      clken_d = '0;
    end else begin
      case (state_q)
        ST_IDLE:   if (start_i) state_d = ST_SUPPLY;
        ST_SUPPLY: begin
          state_d = ST_CLK;
          idx_d   = '0;
          clken_d = NUM_CLK'(1);
        end
        ST_CLK: begin
          if (clk_fail_i[idx_q]) begin
            state_d = ST_UNWIND;
          end else if (idx_q == IW'(NUM_CLK - 1)) begin
            state_d    = ST_PD_REL;
            tmr_load_o = 1'b1;
            tmr_val_o  = TW'(PD_CYC - 1);
          end else begin
            idx_d   = idx_q + IW'(1);
            clken_d = (clken_q << 1) | NUM_CLK'(1);
          end
        end
        ST_UNWIND: begin
          // enables are contiguous from bit 0: a right shift drops the newest
          if (clken_q == '0) state_d = ST_IDLE;
          else               clken_d = clken_q >> 1;
        end
        ST_PD_REL: if (tmr_done_i) begin
          state_d    = ST_SETTLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(SETTLE_CYC - 1);
        end
        ST_SETTLE: if (tmr_done_i) begin
          state_d    = ST_EP_HOLD;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(HOLD_CYC - 1);
        end
        ST_EP_HOLD: if (tmr_done_i) state_d = ST_EP_REL;
        ST_EP_REL: begin
          state_d    = ST_POLL;
          tries_d    = '0;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(POLL_CYC - 1);
        end
        ST_POLL: if (tmr_done_i) begin
          if (lock_i) begin
            state_d = ST_CORE_REL;
          end else if (tries_q == RW'(LOCK_TRIES - 1)) begin
            state_d = ST_TIMEOUT;
          end else begin
            tries_d    = tries_q + RW'(1);
            tmr_load_o = 1'b1;
            tmr_val_o  = TW'(POLL_CYC - 1);
          end
        end
        ST_CORE_REL: state_d = ST_READY;
        ST_READY:    state_d = ST_READY;
        ST_TIMEOUT:  state_d = ST_TIMEOUT;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tries_q <= '0;
      clken_q <= '0;
      out_q   <= LPS_OUT_RST;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tries_q <= tries_d;
      clken_q <= clken_d;
      out_q   <= decode(state_d);
    end
  end

  assign clk_en_o = clken_q;
  assign out_o    = out_q;

  generate
    for (genvar g = 1; g < NUM_CLK; g++) begin : g_order
      AST_CLK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        clken_q[g] |-> clken_q[g-1]);  // R2
    end
  endgenerate

  AST_SUPPLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (clken_q != '0) |-> out_q.supply);  // R10

  AST_REF_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.refclk |-> !out_q.phy_pd);  // R3

  AST_READY_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q.ready) |-> $past(!out_q.core_rst));  // R9

  AST_TIMEOUT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.timeout |-> (!out_q.ready && out_q.core_rst));  // R8

  AST_SHUTDOWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (!out_q.supply && clken_q == '0 && out_q.phy_pd));  // R11

endmodule

// File: rtl/link_pwrup_seq.sv
module link_pwrup_seq
  import lps_pkg::*;
#(
  parameter int unsigned NUM_CLK    = 3,
  parameter int unsigned REF_KHZ    = 100000,
  parameter int unsigned PD_US      = 10,
  parameter int unsigned SETTLE_US  = 200,
  parameter int unsigned HOLD_US    = 100000,
  parameter int unsigned POLL_US    = 50,
  parameter int unsigned LOCK_TRIES = 2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               shutdown_i,
  input  logic               ep_active_hi_i,
  input  logic [NUM_CLK-1:0] clk_fail_i,
  input  logic               pll_lock_i,
  output logic               supply_en_o,
  output logic [NUM_CLK-1:0] clk_en_o,
  output logic               phy_pd_o,
  output logic               refclk_en_o,
  output logic               ep_rst_o,
  output logic               phy_rst_o,
  output logic               core_rst_o,
  output logic               ready_o,
  output logic               lock_timeout_o
);

  localparam int unsigned PD_CYC     = int'(us2cyc(64'(REF_KHZ), 64'(PD_US)));
  localparam int unsigned SETTLE_CYC = int'(us2cyc(64'(REF_KHZ), 64'(SETTLE_US)));
  localparam int unsigned HOLD_CYC   = int'(us2cyc(64'(REF_KHZ), 64'(HOLD_US)));
  localparam int unsigned POLL_CYC   = int'(us2cyc(64'(REF_KHZ), 64'(POLL_US)));
  localparam int unsigned MAX_A      = (PD_CYC > SETTLE_CYC) ? PD_CYC : SETTLE_CYC;
  localparam int unsigned MAX_B      = (HOLD_CYC > POLL_CYC) ? HOLD_CYC : POLL_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW         = $clog2(MAX_CYC + 1);

  logic          lock_sync;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_done;
  lps_out_t      seq_out;

  lps_sync2 #(.STAGES(2)) u_lock_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pll_lock_i),
    .sync_o  (lock_sync)
  );

  lps_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  lps_fsm #(
    .NUM_CLK    (NUM_CLK),
    .TW         (TW),
    .LOCK_TRIES (LOCK_TRIES),
    .PD_CYC     (PD_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .POLL_CYC   (POLL_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .shutdown_i (shutdown_i),
    .clk_fail_i (clk_fail_i),
    .lock_i     (lock_sync),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .clk_en_o   (clk_en_o),
    .out_o      (seq_out)
  );

  assign supply_en_o    = seq_out.supply;
  assign phy_pd_o       = seq_out.phy_pd;
  assign refclk_en_o    = seq_out.refclk;
  assign ep_rst_o       = seq_out.ep_asserted ? ep_active_hi_i : ~ep_active_hi_i;
  assign phy_rst_o      = seq_out.phy_rst;
  assign core_rst_o     = seq_out.core_rst;
  assign ready_o        = seq_out.ready;
  assign lock_timeout_o = seq_out.timeout;

endmodule

// File: tb/sim_link_pwrup_seq.sv
module sim_link_pwrup_seq;

  localparam int NCLK    = 3;
  localparam int KHZ     = 2000;
  localparam int PD_US   = 3;
  localparam int SET_US  = 5;
  localparam int HOLD_US = 8;
  localparam int POLL_US = 2;
  localparam int TRIES   = 4;
  localparam int PD      = (KHZ * PD_US + 999) / 1000;
  localparam int SET     = (KHZ * SET_US + 999) / 1000;
  localparam int HOLD    = (KHZ * HOLD_US + 999) / 1000;
  localparam int P       = (KHZ * POLL_US + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n, start, shutdown, ep_pol, lock;
  logic [NCLK-1:0] fail;
  logic supply, phy_pd, refclk, ep_rst, phy_rst, core_rst, ready, tmo;
  logic [NCLK-1:0] clk_en;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  link_pwrup_seq #(
    .NUM_CLK(NCLK), .REF_KHZ(KHZ), .PD_US(PD_US), .SETTLE_US(SET_US),
    .HOLD_US(HOLD_US), .POLL_US(POLL_US), .LOCK_TRIES(TRIES)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .shutdown_i(shutdown),
    .ep_active_hi_i(ep_pol), .clk_fail_i(fail), .pll_lock_i(lock),
    .supply_en_o(supply), .clk_en_o(clk_en), .phy_pd_o(phy_pd),
    .refclk_en_o(refclk), .ep_rst_o(ep_rst), .phy_rst_o(phy_rst),
    .core_rst_o(core_rst), .ready_o(ready), .lock_timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(supply == 1'b0, req, int'(supply), 0);
    chk(clk_en == '0, req, int'(clk_en), 0);
    chk(phy_pd == 1'b1 && refclk == 1'b0, req, int'({phy_pd, refclk}), 2);
    chk(phy_rst == 1'b1 && core_rst == 1'b1, req, int'({phy_rst, core_rst}), 3);
    chk(ep_rst == ep_pol, req, int'(ep_rst), int'(ep_pol));  // R5 active level
    chk(ready == 1'b0 && tmo == 1'b0, req, int'({ready, tmo}), 0);
  endtask

  // R11: shutdown with start raised at the same edge
  task automatic do_shutdown();
    @(negedge clk);
    shutdown = 1'b1;
    start    = 1'b1;
    @(negedge clk);
    check_idle("R11");
    shutdown = 1'b0;
    start    = 1'b0;
  endtask

  // tgt: -2 lock always high, -1 never, >=0 cycles after PHY reset release
  task automatic run_case(input bit pol, input int fk, input int tgt);
    int t_sup, t_c0, t_c1, t_c2, t_pd, t_ref, t_ep, t_phy, t_core, t_rdy, t_to;
    int k, exp_n, peak;
    logic [NCLK-1:0] prev;
    bit sup_seen, ord_ok;
    ep_pol = pol;
    lock   = (tgt == -2);
    fail   = '0;
    if (fk < NCLK) fail[fk] = 1'b1;
    do_shutdown();
    t_sup = -1; t_c0 = -1; t_c1 = -1; t_c2 = -1; t_pd = -1; t_ref = -1;
    t_ep = -1; t_phy = -1; t_core = -1; t_rdy = -1; t_to = -1;
    prev = '0; sup_seen = 0; ord_ok = 1; peak = 0;
    start = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (supply && t_sup < 0) t_sup = i;
      if (clk_en[0] && t_c0 < 0) t_c0 = i;
      if (clk_en[1] && t_c1 < 0) t_c1 = i;
      if (clk_en[2] && t_c2 < 0) t_c2 = i;
      if (!phy_pd && t_pd < 0) t_pd = i;
      if (refclk && t_ref < 0) t_ref = i;
      if (ep_rst != pol && t_ep < 0) t_ep = i;
      if (!phy_rst && t_phy < 0) t_phy = i;
      if (!core_rst && t_core < 0) t_core = i;
      if (ready && t_rdy < 0) t_rdy = i;
      if (tmo && t_to < 0) t_to = i;
      if (int'(clk_en) > peak) peak = int'(clk_en);
      if (clk_en != prev && clk_en < prev && clk_en != (prev >> 1)) ord_ok = 0;
      if (!supply && clk_en != '0) ord_ok = 0;
      prev = clk_en;
      if (supply) sup_seen = 1;
      if (t_phy >= 0 && tgt >= 0 && (i - t_phy) == tgt) lock = 1'b1;
      if (t_rdy >= 0 || t_to >= 0) break;
      if (sup_seen && !supply) break;
    end
    if (fk < NCLK) begin
      chk(peak == (1 << (fk + 1)) - 1, "R10", peak, (1 << (fk + 1)) - 1);
      chk(ord_ok, "R10", int'(ord_ok), 1);
      chk(supply == 1'b0 && clk_en == '0, "R10", int'({supply, clk_en}), 0);
      chk(t_pd == -1 && t_rdy == -1, "R10", t_pd, -1);
    end else begin
      chk(t_sup == 0 && t_c0 == 1, "R2", t_c0, 1);
      chk(t_c1 == 2 && t_c2 == 3, "R2", t_c2, 3);
      chk(t_pd == 4, "R2", t_pd, 4);
      chk(t_ref - t_pd == PD, "R3", t_ref - t_pd, PD);
      chk(t_ep - t_ref == SET + HOLD, "R4", t_ep - t_ref, SET + HOLD);
      chk(ep_rst == !pol, "R5", int'(ep_rst), int'(!pol));
      chk(t_phy - t_ep == 1, "R6", t_phy - t_ep, 1);
      if (tgt == -2) k = 1;
      else if (tgt == -1) k = TRIES + 1;
      else begin
        k = (tgt + 3 + P - 1) / P;
        if (k < 1) k = 1;
      end
      if (k <= TRIES) begin
        exp_n = k * P + 1;
        chk(t_rdy - t_phy == exp_n, "R7", t_rdy - t_phy, exp_n);
        chk(t_core == t_rdy - 1, "R9", t_core, t_rdy - 1);
        chk(tmo == 1'b0, "R8", int'(tmo), 0);
        @(negedge clk);
        @(negedge clk);
        chk(ready == 1'b1, "R9", int'(ready), 1);
      end else begin
        chk(t_to - t_phy == TRIES * P, "R8", t_to - t_phy, TRIES * P);
        chk(ready == 1'b0 && core_rst == 1'b1, "R8", int'({ready, core_rst}), 1);
      end
    end
  endtask

  // R11 sweep: shutdown at every cycle of a bring-up
  task automatic shut_at(input int d);
    ep_pol = d[0];
    lock   = 1'b1;
    fail   = '0;
    do_shutdown();
    start = 1'b1;
    for (int i = 0; i <= d; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
    shutdown = 1'b1;
    @(negedge clk);
    shutdown = 1'b0;
    check_idle("R11");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; shutdown = 1'b0; ep_pol = 1'b0;
    lock = 1'b0; fail = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    ep_pol = 1'b1;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    for (int pol = 0; pol < 2; pol++) begin
      run_case(pol[0], NCLK, -2);
      run_case(pol[0], NCLK, -1);
      for (int t = 0; t < TRIES * P; t++) run_case(pol[0], NCLK, t);
      for (int f = 0; f < NCLK; f++) run_case(pol[0], f, -2);
    end
    for (int d = 0; d < 4 + PD + SET + HOLD + P + 4; d++) shut_at(d);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule